// File: doc/BRIEF.md
# One-Wire Write Frame Parser

This block sits behind a pulse-width bit decoder on a single configuration wire. The decoder gives it one decoded bit at a time and a level that says the wire is idle. The parser builds write frames from those bits. Each frame opens with a start bit of 1. A command field comes next and selects the frame type. A short frame writes one register of the register bank: it has a 5-bit address and an 8-bit value. A long frame writes one word of the EEPROM bank: it has a 3-bit address and a 32-bit value. Every frame closes with a stop bit of 0.

When a frame is complete and correct, the parser raises a one-cycle write strobe on the port for that bank, with the address and the data beside it. It drops any frame that is cut short by idle, that has a bad stop bit, or that carries an unknown command. A frame only counts when it begins on a wire that has been idle. There is no read path.

Top module: `owf_frame_parser`

## Requirements
- R1: After reset, both strobes are low and all address and data outputs are zero. Bits that arrive before the first idle indication are ignored.
- R2: The bits start 1, command 0 0, five address bits MSB first, eight data bits MSB first, stop 0 form a register write. The cycle after the stop bit is accepted, `reg_wr_stb` is high and `reg_wr_addr`/`reg_wr_data` carry the fields.
- R3: The bits start 1, command 0 1 0 1 (first bit sent first), three address bits MSB first, 32 data bits MSB first, stop 0 form an EEPROM write. The cycle after the stop bit, `ee_wr_stb` is high and `ee_wr_addr`/`ee_wr_data` carry the fields.
- R4: Each accepted frame raises exactly one strobe for exactly one clock cycle. The two strobes are never high together.
- R5: A stop bit of 1 drops the frame and no strobe is raised. The parser then waits for idle before it accepts a new start bit.
- R6: An idle indication before the stop bit drops the frame at once. A start bit that follows is accepted as a new frame.
- R7: If the command is neither 0 0 nor 0 1 0 1, the rest of the frame is ignored until the wire returns to idle.
- R8: If the first bit after idle is 0, it is not a start bit. All bits are ignored until the next idle.
- R9: After a frame completes, a new frame is accepted only after an idle indication.
- R10: Between strobes, the address and data outputs of each port hold their last written values. A write to one port leaves the other port's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | One-cycle pulse: a decoded bit is present |
| bit_val | input | 1 | Value of the decoded bit |
| line_idle | input | 1 | High while the wire is idle |
| reg_wr_stb | output | 1 | Register-bank write strobe |
| reg_wr_addr | output | 5 | Register-bank write address |
| reg_wr_data | output | 8 | Register-bank write data |
| ee_wr_stb | output | 1 | EEPROM-bank write strobe |
| ee_wr_addr | output | 3 | EEPROM-bank write address |
| ee_wr_data | output | 32 | EEPROM-bank write data |

## Verification
A wrong field count or a wrong shift order shows on the write ports in the cycle after the stop bit. The symptom is one of three: a strobe with a misplaced address or value, a strobe on the wrong bank, or no strobe at all. A frame-state error that misses an idle, a stop bit or a command mismatch shows as a strobe that should not appear, either for the bad frame or for a later frame sent without idle in between. The tests are built so that each kind of error produces a strobe, or fails to, in that exact cycle. Outputs that change without a strobe show within one cycle at the held address and data.

// File: rtl/owf_pkg.sv
package owf_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_IDLE,
    ST_READY,
    ST_CMD,
    ST_FIELD,
    ST_STOP
  } owf_state_e;

  typedef enum logic [1:0] {
    K_PEND,
    K_NONE,
    K_SHORT,
    K_LONG
  } owf_kind_e;
endpackage

// File: rtl/owf_cmd_decode.sv
module owf_cmd_decode
  import owf_pkg::*;
#(
  parameter int CMD_W       = 4,
  parameter int SHORT_CMD_W = 2,
  parameter logic [SHORT_CMD_W-1:0] SHORT_CMD = '0,
  parameter logic [CMD_W-1:0]       LONG_CMD  = 4'b0101,
  localparam int CNT_W = $clog2(CMD_W + 1)
) (
  input  logic [CMD_W-1:0] cmd_bits,
  input  logic [CNT_W-1:0] cmd_cnt,
  output owf_kind_e        kind
);
  always_comb begin
    kind = K_PEND;
    if (cmd_cnt == CNT_W'(SHORT_CMD_W) && cmd_bits[SHORT_CMD_W-1:0] == SHORT_CMD)
      kind = K_SHORT;
    else if (cmd_cnt == CNT_W'(CMD_W))
      kind = (cmd_bits == LONG_CMD) ? K_LONG : K_NONE;
  end
endmodule

// File: rtl/owf_shifter.sv
module owf_shifter #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift_en) q <= {q[W-2:0], bit_in};
  end
endmodule

// File: rtl/owf_port_reg.sv
module owf_port_reg #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          stb,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stb  <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      stb <= load;
      if (load) begin
        addr <= addr_in;
        data <= data_in;
      end
    end
  end
endmodule

// File: rtl/owf_frame_parser.sv
module owf_frame_parser
  import owf_pkg::*;
#(
  parameter int REG_AW      = 5,
  parameter int REG_DW      = 8,
  parameter int EE_AW       = 3,
  parameter int EE_DW       = 32,
  parameter int CMD_W       = 4,
  parameter int SHORT_CMD_W = 2,
  parameter logic [SHORT_CMD_W-1:0] SHORT_CMD = '0,
  parameter logic [CMD_W-1:0]       LONG_CMD  = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              line_idle,
  output logic              reg_wr_stb,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [REG_DW-1:0] reg_wr_data,
  output logic              ee_wr_stb,
  output logic [EE_AW-1:0]  ee_wr_addr,
  output logic [EE_DW-1:0]  ee_wr_data
);
  localparam int SHORT_LEN = REG_AW + REG_DW;
  localparam int LONG_LEN  = EE_AW + EE_DW;
  localparam int PAY_W     = (SHORT_LEN > LONG_LEN) ? SHORT_LEN : LONG_LEN;
  localparam int FCNT_W    = $clog2(PAY_W + 1);
  localparam int CCNT_W    = $clog2(CMD_W + 1);

  owf_state_e        state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CCNT_W-1:0] cmd_cnt_q;
  logic [FCNT_W-1:0] fld_left_q;
  logic              is_long_q;
  logic [PAY_W-1:0]  pay_q;

  logic [CMD_W-1:0]  cmd_next;
  logic [CCNT_W-1:0] cmd_cnt_next;
  owf_kind_e         kind;
  logic              bit_in;
  logic              start_ok;
  logic              shift_en;
  logic              stop_good;

  assign bit_in       = bit_valid && !line_idle;
  assign cmd_next     = {cmd_q[CMD_W-2:0], bit_val};
  assign cmd_cnt_next = cmd_cnt_q + 1'b1;
  assign start_ok     = (state_q == ST_READY) && bit_valid && bit_val;
  assign shift_en     = (state_q == ST_FIELD) && bit_in;
  assign stop_good    = (state_q == ST_STOP) && bit_in && !bit_val;

  owf_cmd_decode #(
    .CMD_W(CMD_W), .SHORT_CMD_W(SHORT_CMD_W),
    .SHORT_CMD(SHORT_CMD), .LONG_CMD(LONG_CMD)
  ) u_dec (
    .cmd_bits(cmd_next),
    .cmd_cnt (cmd_cnt_next),
    .kind    (kind)
  );

  owf_shifter #(.W(PAY_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clr     (start_ok),
    .shift_en(shift_en),
    .bit_in  (bit_val),
    .q       (pay_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_WAIT_IDLE;
      cmd_q      <= '0;
      cmd_cnt_q  <= '0;
      fld_left_q <= '0;
      is_long_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT_IDLE: if (line_idle) state_q <= ST_READY;
        ST_READY: begin
          if (bit_valid) begin
            state_q   <= bit_val ? ST_CMD : ST_WAIT_IDLE;
            cmd_q     <= '0;
            cmd_cnt_q <= '0;
          end
        end
        ST_CMD: begin
          if (line_idle) state_q <= ST_READY;
          else if (bit_valid) begin
            cmd_q     <= cmd_next;
            cmd_cnt_q <= cmd_cnt_next;
            unique case (kind)
              K_SHORT: begin
                state_q    <= ST_FIELD;
                is_long_q  <= 1'b0;
                fld_left_q <= FCNT_W'(SHORT_LEN);
              end
              K_LONG: begin
                state_q    <= ST_FIELD;
                is_long_q  <= 1'b1;
                fld_left_q <= FCNT_W'(LONG_LEN);
              end
              K_NONE:  state_q <= ST_WAIT_IDLE;
              default: state_q <= ST_CMD;
            endcase
          end
        end
        ST_FIELD: begin
          if (line_idle) state_q <= ST_READY;
          else if (bit_valid) begin
            fld_left_q <= fld_left_q - 1'b1;
            if (fld_left_q == FCNT_W'(1)) state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (line_idle) state_q <= ST_READY;
          else if (bit_valid) state_q <= ST_WAIT_IDLE;
        end
        default: state_q <= ST_WAIT_IDLE;
      endcase
    end
  end

  owf_port_reg #(.AW(REG_AW), .DW(REG_DW)) u_reg_port (
    .clk    (clk),
    .rst    (rst),
    .load   (stop_good && !is_long_q),
    .addr_in(pay_q[SHORT_LEN-1 -: REG_AW]),
    .data_in(pay_q[REG_DW-1:0]),
    .stb    (reg_wr_stb),
    .addr   (reg_wr_addr),
    .data   (reg_wr_data)
  );

  owf_port_reg #(.AW(EE_AW), .DW(EE_DW)) u_ee_port (
    .clk    (clk),
    .rst    (rst),
    .load   (stop_good && is_long_q),
    .addr_in(pay_q[LONG_LEN-1 -: EE_AW]),
    .data_in(pay_q[EE_DW-1:0]),
    .stb    (ee_wr_stb),
    .addr   (ee_wr_addr),
    .data   (ee_wr_data)
  );
endmodule

// File: rtl/owf_frame_parser_chk.sv
module owf_frame_parser_chk #(
  parameter int REG_AW = 5,
  parameter int REG_DW = 8,
  parameter int EE_AW  = 3,
  parameter int EE_DW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_valid,
  input logic              bit_val,
  input logic              line_idle,
  input logic              reg_wr_stb,
  input logic [REG_AW-1:0] reg_wr_addr,
  input logic [REG_DW-1:0] reg_wr_data,
  input logic              ee_wr_stb,
  input logic [EE_AW-1:0]  ee_wr_addr,
  input logic [EE_DW-1:0]  ee_wr_data
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!reg_wr_stb && !ee_wr_stb));

  a_r4_single_cycle_reg: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);

  a_r4_single_cycle_ee: assert property (@(posedge clk) disable iff (rst)
    ee_wr_stb |=> !ee_wr_stb);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_stb && ee_wr_stb));

  a_r5_stop_was_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_stb || ee_wr_stb) |-> $past(bit_valid && !bit_val));

  a_r6_no_strobe_after_idle: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_stb || ee_wr_stb) |-> !$past(line_idle));

  a_r10_reg_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_wr_stb || ($stable(reg_wr_addr) && $stable(reg_wr_data))));

  a_r10_ee_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ee_wr_stb || ($stable(ee_wr_addr) && $stable(ee_wr_data))));
endmodule

bind owf_frame_parser owf_frame_parser_chk #(
  .REG_AW(REG_AW), .REG_DW(REG_DW), .EE_AW(EE_AW), .EE_DW(EE_DW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_valid  (bit_valid),
  .bit_val    (bit_val),
  .line_idle  (line_idle),
  .reg_wr_stb (reg_wr_stb),
  .reg_wr_addr(reg_wr_addr),
  .reg_wr_data(reg_wr_data),
  .ee_wr_stb  (ee_wr_stb),
  .ee_wr_addr (ee_wr_addr),
  .ee_wr_data (ee_wr_data)
);

// File: tb/owf_frame_parser_bench.sv
`timescale 1ns/1ps
module owf_frame_parser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_valid = 1'b0;
  logic        bit_val = 1'b0;
  logic        line_idle = 1'b0;
  logic        reg_wr_stb;
  logic [4:0]  reg_wr_addr;
  logic [7:0]  reg_wr_data;
  logic        ee_wr_stb;
  logic [2:0]  ee_wr_addr;
  logic [31:0] ee_wr_data;

  int n_chk = 0;
  int n_bad = 0;
  int reg_cnt = 0;
  int ee_cnt = 0;
  int both_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  owf_frame_parser u_owf_frame_parser (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_val(bit_val),
    .line_idle(line_idle), .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .ee_wr_stb(ee_wr_stb), .ee_wr_addr(ee_wr_addr),
    .ee_wr_data(ee_wr_data)
  );

  always @(negedge clk) begin
    if (reg_wr_stb) reg_cnt++;
    if (ee_wr_stb) ee_cnt++;
    if (reg_wr_stb && ee_wr_stb) both_cnt++;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    line_idle = 1'b0;
    bit_valid = 1'b1;
    bit_val   = b;
    @(negedge clk);
    bit_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    bit_valid = 1'b0;
    line_idle = 1'b1;
    repeat (3) @(negedge clk);
    line_idle = 1'b0;
  endtask

  task automatic send_reg(logic [4:0] a, logic [7:0] d, logic stop);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b0);
    for (int i = 4; i >= 0; i--) send_bit(a[i]);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(stop);
  endtask

  task automatic send_ee(logic [3:0] c, logic [2:0] a, logic [31:0] d, logic stop);
    send_bit(1'b1);
    for (int i = 3; i >= 0; i--) send_bit(c[i]);
    for (int i = 2; i >= 0; i--) send_bit(a[i]);
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    send_bit(stop);
  endtask

  task automatic counts(string req, int er, int ee, int r0, int e0);
    repeat (2) @(negedge clk);
    chk(req, 64'(reg_cnt - r0), 64'(er));
    chk(req, 64'(ee_cnt - e0), 64'(ee));
  endtask

  task automatic t_reset();
    chk("R1 reg strobe", 64'(reg_wr_stb), 64'd0);
    chk("R1 ee strobe", 64'(ee_wr_stb), 64'd0);
    chk("R1 outputs zero", 64'({reg_wr_addr, reg_wr_data, ee_wr_addr}), 64'd0);
    chk("R1 ee data zero", 64'(ee_wr_data), 64'd0);
    begin
      int r0 = reg_cnt, e0 = ee_cnt;
      send_reg(5'h0B, 8'hC6, 1'b0);
      counts("R1 no frame before idle", 0, 0, r0, e0);
    end
  endtask

  task automatic t_reg(logic [4:0] a, logic [7:0] d);
    int r0 = reg_cnt, e0 = ee_cnt;
    go_idle();
    send_reg(a, d, 1'b0);
    counts("R2 R4 one reg strobe", 1, 0, r0, e0);
    chk("R2 reg addr", 64'(reg_wr_addr), 64'(a));
    chk("R2 reg data", 64'(reg_wr_data), 64'(d));
  endtask

  task automatic t_ee(logic [2:0] a, logic [31:0] d);
    int r0 = reg_cnt, e0 = ee_cnt;
    logic [12:0] reg_before = {reg_wr_addr, reg_wr_data};
    go_idle();
    send_ee(4'b0101, a, d, 1'b0);
    counts("R3 R4 one ee strobe", 0, 1, r0, e0);
    chk("R3 ee addr", 64'(ee_wr_addr), 64'(a));
    chk("R3 ee data", 64'(ee_wr_data), 64'(d));
    chk("R10 reg port held", 64'({reg_wr_addr, reg_wr_data}), 64'(reg_before));
  endtask

  task automatic t_bad_stop();
    int r0 = reg_cnt, e0 = ee_cnt;
    go_idle();
    send_reg(5'h03, 8'h3C, 1'b1);
    counts("R5 bad stop dropped", 0, 0, r0, e0);
    send_reg(5'h04, 8'h44, 1'b0);
    counts("R5 needs idle after bad stop", 0, 0, r0, e0);
    t_reg(5'h04, 8'h44);
  endtask

  task automatic t_trunc();
    int r0 = reg_cnt, e0 = ee_cnt;
    go_idle();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0);
    go_idle();
    counts("R6 cut in address dropped", 0, 0, r0, e0);
    send_bit(1'b1); send_bit(1'b0);
    go_idle();
    counts("R6 cut in command dropped", 0, 0, r0, e0);
    send_ee(4'b0101, 3'h6, 32'h1234_5678, 1'b0);
    counts("R6 new frame right after idle", 0, 1, r0, e0);
    chk("R6 ee data", 64'(ee_wr_data), 64'h1234_5678);
  endtask

  task automatic t_bad_cmd(logic [3:0] c);
    int r0 = reg_cnt, e0 = ee_cnt;
    go_idle();
    send_bit(1'b1);
    for (int i = 3; i >= 0; i--) send_bit(c[i]);
    send_reg(5'h11, 8'h22, 1'b0);
    send_ee(4'b0101, 3'h1, 32'hDEAD_0001, 1'b0);
    counts("R7 unknown command ignored", 0, 0, r0, e0);
  endtask

  task automatic t_zero_start();
    int r0 = reg_cnt, e0 = ee_cnt;
    go_idle();
    send_bit(1'b0);
    send_reg(5'h15, 8'h5A, 1'b0);
    counts("R8 zero first bit ignored", 0, 0, r0, e0);
  endtask

  task automatic t_back_to_back();
    int r0 = reg_cnt, e0 = ee_cnt;
    go_idle();
    send_reg(5'h07, 8'h70, 1'b0);
    send_reg(5'h08, 8'h80, 1'b0);
    counts("R9 second frame without idle ignored", 1, 0, r0, e0);
    chk("R9 first frame kept", 64'({reg_wr_addr, reg_wr_data}), 64'({5'h07, 8'h70}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg(5'h0B, 8'hC6);
    t_reg(5'h1F, 8'h01);
    t_ee(3'h5, 32'hA5C3_0F96);
    t_ee(3'h2, 32'h8000_0001);
    t_bad_stop();
    t_trunc();
    t_bad_cmd(4'b0111);
    t_bad_cmd(4'b1001);
    t_zero_start();
    t_back_to_back();
    chk("R4 strobes never together", 64'(both_cnt), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule